// File: doc/BRIEF.md
# H-Bridge Gate Command Sequencer with Dead-Time

This block converts four control inputs into the on/off commands for the four switches of an H-bridge: the low and high switches of leg A and of leg B. The control inputs are a direction bit from a comparator, a high-side enable, a disable line and an undervoltage flag. A fixed-priority decode chooses, for each leg, whether its high switch, its low switch or neither is requested. A per-leg sequencer then turns the decoded requests into outputs.

The sequencer removes an output as soon as its request goes away. It delays each turn-on by a programmable dead-time that starts when the other switch on the same leg turns off. One 8-bit count sets the dead-time for both high switches. A separate count sets it for both low switches, so the two paths can be balanced independently. All outputs are registered, so the sequencer adds one clock of latency.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `dis_i` is 1 at a rising edge, all four outputs are 0 after that edge, whatever the other inputs are.
- R2: While `uv_i` is 1 at a rising edge, all four outputs are 0 after that edge.
- R3: With `hs_en_i`=1, `dis_i`=0 and `uv_i`=0, the requests depend on `dir_i` as follows. `dir_i`=1 requests A-high and B-low. `dir_i`=0 requests A-low and B-high. Each requested output turns on after its dead-time.
- R4: With `hs_en_i`=0, both high outputs stay 0. `dir_i`=1 requests only B-low, and `dir_i`=0 requests only A-low.
- R5: An output that is on falls at the first rising edge that samples inputs no longer requesting it. Turn-off has no added delay.
- R6: Let edge n be the first rising edge of an unbroken run of edges that all request a given switch. That switch turns on at edge n+D+1. D is `hi_dly_i` for a high switch and `lo_dly_i` for a low switch. The switch then stays on for as long as the run lasts.
- R7: With a dead-time count of 0, each commutation of a leg still leaves exactly one cycle in which both switches of that leg are off.
- R8: The high switches take their dead-time only from `hi_dly_i`, and the low switches take theirs only from `lo_dly_i`.
- R9: If a leg's request changes before a pending turn-on completes, that turn-on is cancelled. The dead-time count restarts for the new request from the edge that samples it.
- R10: The high and low outputs of one leg are never 1 in the same cycle.
- R11: While `rst_n` is 0, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Comparator direction bit |
| hs_en_i | input | 1 | High-side enable |
| dis_i | input | 1 | Disable, highest priority |
| uv_i | input | 1 | Undervoltage flag |
| hi_dly_i | input | 8 | Dead-time count for the high switches |
| lo_dly_i | input | 8 | Dead-time count for the low switches |
| a_lo_o | output | 1 | Leg A low switch command |
| a_hi_o | output | 1 | Leg A high switch command |
| b_lo_o | output | 1 | Leg B low switch command |
| b_hi_o | output | 1 | Leg B high switch command |

## Verification
The bench sweeps grids of high and low dead-time counts, including zero, under random direction, enable, disable and undervoltage patterns. It computes every output from the run length of each switch's request. A zero count is exercised specifically: a sequencer that skipped the count would shoot through, with both switches of a leg on together or switched within the same cycle. Fast reversals shorter than the dead-time are also driven. A design that failed to cancel the pending turn-on would switch on a stale switch, and one that kept the old count would turn on too early. Asymmetric counts expose a swapped delay select, and holding requests while switches are on exposes a turn-off that is wrongly delayed.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Per-leg request produced by the decode and consumed by each leg sequencer.
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_req_e;

  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic     dir_i,
  input  logic     hs_en_i,
  input  logic     dis_i,
  input  logic     uv_i,
  output leg_req_e a_req_o,
  output leg_req_e b_req_o
);
  logic blocked;

  always_comb begin
    blocked = dis_i | uv_i;
    a_req_o = LEG_OFF;
    b_req_o = LEG_OFF;
    if (!blocked) begin
      if (dir_i) begin
        b_req_o = LEG_LO;
        if (hs_en_i) a_req_o = LEG_HI;
      end else begin
        a_req_o = LEG_LO;
        if (hs_en_i) b_req_o = LEG_HI;
      end
    end
  end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  leg_req_e         req_i,
  input  logic [DLY_W-1:0] hi_dly_i,
  input  logic [DLY_W-1:0] lo_dly_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic             hi_q, hi_d;
  logic             lo_q, lo_d;
  leg_req_e         tgt_q, tgt_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             out_en, tgt_en, cnt_en;
  logic [DLY_W-1:0] dly_sel;
  logic             own_on;

  // Next-state process
  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    out_en  = 1'b0;
    tgt_en  = 1'b0;
    cnt_en  = 1'b0;
    dly_sel = (req_i == LEG_HI) ? hi_dly_i : lo_dly_i;
    own_on  = (req_i == LEG_HI) ? hi_q : lo_q;
    case (req_i)
      LEG_HI, LEG_LO: begin
        if (own_on) begin
          // Requested switch already conducting: hold.
        end else if (hi_q || lo_q || (tgt_q != req_i)) begin
          // Opposite switch drops now; dead-time starts at this edge.
          hi_d   = 1'b0;
          lo_d   = 1'b0;
          out_en = 1'b1;
          tgt_d  = req_i;
          tgt_en = 1'b1;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else if (cnt_q >= dly_sel) begin
          hi_d   = (req_i == LEG_HI);
          lo_d   = (req_i == LEG_LO);
          out_en = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: begin
        hi_d   = 1'b0;
        lo_d   = 1'b0;
        out_en = 1'b1;
        tgt_d  = LEG_OFF;
        tgt_en = 1'b1;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      tgt_q <= LEG_OFF;
      cnt_q <= '0;
    end else begin
      if (out_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      if (tgt_en) tgt_q <= tgt_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             hs_en_i,
  input  logic             dis_i,
  input  logic             uv_i,
  input  logic [DLY_W-1:0] hi_dly_i,
  input  logic [DLY_W-1:0] lo_dly_i,
  output logic             a_lo_o,
  output logic             a_hi_o,
  output logic             b_lo_o,
  output logic             b_hi_o
);
  leg_req_e leg_req [NUM_LEGS];
  logic     leg_hi  [NUM_LEGS];
  logic     leg_lo  [NUM_LEGS];

  hbg_decode u_dec (
    .dir_i   (dir_i),
    .hs_en_i (hs_en_i),
    .dis_i   (dis_i),
    .uv_i    (uv_i),
    .a_req_o (leg_req[0]),
    .b_req_o (leg_req[1])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_leg #(.DLY_W(DLY_W)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (leg_req[g]),
      .hi_dly_i (hi_dly_i),
      .lo_dly_i (lo_dly_i),
      .hi_o     (leg_hi[g]),
      .lo_o     (leg_lo[g])
    );
  end

  assign a_lo_o = leg_lo[0];
  assign a_hi_o = leg_hi[0];
  assign b_lo_o = leg_lo[1];
  assign b_hi_o = leg_hi[1];
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_i,
  input logic hs_en_i,
  input logic dis_i,
  input logic uv_i,
  input logic a_lo_o,
  input logic a_hi_o,
  input logic b_lo_o,
  input logic b_hi_o
);
  AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> !(a_lo_o || a_hi_o || b_lo_o || b_hi_o)); // R1
  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !(a_lo_o || a_hi_o || b_lo_o || b_hi_o)); // R2
  AST_HS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en_i |=> (!a_hi_o && !b_hi_o)); // R4
  AST_AHI_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hi_o && !(hs_en_i && dir_i)) |=> !a_hi_o); // R5
  AST_BLO_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (b_lo_o && !dir_i) |=> !b_lo_o); // R5
  AST_A_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_hi_o) || $rose(a_lo_o)) |-> !$past(a_hi_o || a_lo_o)); // R7
  AST_B_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_hi_o) || $rose(b_lo_o)) |-> !$past(b_hi_o || b_lo_o)); // R7
  AST_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi_o && a_lo_o)); // R10
  AST_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_hi_o && b_lo_o)); // R10
endmodule

bind hbridge_gate_ctrl hbg_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dir_i   (dir_i),
  .hs_en_i (hs_en_i),
  .dis_i   (dis_i),
  .uv_i    (uv_i),
  .a_lo_o  (a_lo_o),
  .a_hi_o  (a_hi_o),
  .b_lo_o  (b_lo_o),
  .b_hi_o  (b_hi_o)
);

// File: tb/hbridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_test;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n, dir_i, hs_en_i, dis_i, uv_i;
  logic [DLY_W-1:0] hi_dly_i, lo_dly_i;
  logic a_lo_o, a_hi_o, b_lo_o, b_hi_o;

  int checks = 0;
  int errors = 0;
  // switch order: 0 A-low, 1 A-high, 2 B-low, 3 B-high
  int run [4];
  bit exp_on [4];

  always #2.5 clk = ~clk;

  hbridge_gate_ctrl #(.DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .hs_en_i(hs_en_i),
    .dis_i(dis_i), .uv_i(uv_i), .hi_dly_i(hi_dly_i), .lo_dly_i(lo_dly_i),
    .a_lo_o(a_lo_o), .a_hi_o(a_hi_o), .b_lo_o(b_lo_o), .b_hi_o(b_hi_o)
  );

  function automatic bit act(int s);
    case (s)
      0: return a_lo_o;
      1: return a_hi_o;
      2: return b_lo_o;
      default: return b_hi_o;
    endcase
  endfunction

  // Advance one clock, update the reference, compare after the edge.
  task automatic step(input string tag);
    bit rq [4];
    bit off;
    int d;
    off   = dis_i | uv_i;                // R1 R2
    rq[1] = !off && hs_en_i && dir_i;    // R3
    rq[0] = !off && !dir_i;              // R3 R4
    rq[2] = !off && dir_i;               // R3 R4
    rq[3] = !off && hs_en_i && !dir_i;   // R3
    for (int s = 0; s < 4; s++) begin
      d = (s == 1 || s == 3) ? int'(hi_dly_i) : int'(lo_dly_i);  // R8
      if (rq[s]) begin
        if (run[s] < 100000) run[s]++;
      end else run[s] = 0;
      exp_on[s] = rq[s] && (exp_on[s] || run[s] >= d + 2);      // R5 R6
    end
    @(posedge clk);
    #1;
    for (int s = 0; s < 4; s++) begin
      checks++;
      if (act(s) !== exp_on[s]) begin
        errors++;
        $display("FAIL %s switch %0d: actual=%0b expected=%0b at %0t", tag, s, act(s), exp_on[s], $time);
      end
    end
    checks++;
    if ((a_lo_o && a_hi_o) || (b_lo_o && b_hi_o)) begin
      errors++;
      $display("FAIL R10 leg overlap: actual=%b%b%b%b expected no pair on", a_lo_o, a_hi_o, b_lo_o, b_hi_o);
    end
    @(negedge clk);
  endtask

  task automatic set_in(input bit d, input bit h, input bit ds, input bit u);
    dir_i = d; hs_en_i = h; dis_i = ds; uv_i = u;
  endtask

  task automatic idle(input int n);
    set_in(0, 0, 1, 0);
    for (int i = 0; i < n; i++) step("R1");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_in(1, 1, 0, 0);
    hi_dly_i = 8'd3; lo_dly_i = 8'd5;
    for (int s = 0; s < 4; s++) begin run[s] = 0; exp_on[s] = 0; end
    repeat (3) @(negedge clk);
    // R11: reset holds outputs low even with an active request
    checks++;
    if ({a_lo_o, a_hi_o, b_lo_o, b_hi_o} !== 4'b0) begin
      errors++;
      $display("FAIL R11 reset: actual=%b%b%b%b expected=0000", a_lo_o, a_hi_o, b_lo_o, b_hi_o);
    end
    set_in(0, 0, 1, 0);
    rst_n = 1'b1;
    step("R11");

    // R3: high side enabled, both directions
    set_in(1, 1, 0, 0);
    for (int i = 0; i < 12; i++) step("R3");
    set_in(0, 1, 0, 0);
    for (int i = 0; i < 12; i++) step("R3");
    // R4: high side disabled
    set_in(1, 0, 0, 0);
    for (int i = 0; i < 12; i++) step("R4");
    set_in(0, 0, 0, 0);
    for (int i = 0; i < 12; i++) step("R4");
    // R1 / R2 overriding active drive
    set_in(1, 1, 0, 0);
    for (int i = 0; i < 10; i++) step("R3");
    set_in(1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step("R1");
    set_in(1, 1, 0, 0);
    for (int i = 0; i < 10; i++) step("R6");
    set_in(1, 1, 0, 1);
    for (int i = 0; i < 3; i++) step("R2");
    set_in(1, 1, 1, 1);
    for (int i = 0; i < 2; i++) step("R1");

    // R8: strongly asymmetric counts
    idle(3);
    hi_dly_i = 8'd2; lo_dly_i = 8'd9;
    set_in(1, 1, 0, 0);
    for (int i = 0; i < 14; i++) step("R8");
    set_in(0, 1, 0, 0);
    for (int i = 0; i < 14; i++) step("R8");

    // R7: zero dead-time, frequent commutation
    idle(3);
    hi_dly_i = 8'd0; lo_dly_i = 8'd0;
    for (int i = 0; i < 30; i++) begin
      set_in(((i / 3) % 2) == 1, 1, 0, 0);
      step("R7");
    end

    // R9: reversals faster than the dead-time, then settle
    idle(3);
    hi_dly_i = 8'd6; lo_dly_i = 8'd4;
    for (int i = 0; i < 20; i++) begin
      set_in(((i / 2) % 2) == 1, 1, 0, 0);
      step("R9");
    end
    set_in(1, 1, 0, 0);
    for (int i = 0; i < 12; i++) step("R9");
    set_in(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step("R9");
    set_in(1, 1, 0, 0);
    for (int i = 0; i < 12; i++) step("R9");

    // R5 R6: random sweep over a grid of dead-time counts
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 4; l++) begin
        idle(2);
        hi_dly_i = DLY_W'((h * h) + (h / 3));
        lo_dly_i = DLY_W'((l * 2) + (l / 3));
        for (int i = 0; i < 70; i++) begin
          int r;
          r = $urandom_range(0, 99);
          set_in(r[0] ^ (i % 9 < 4), r < 85, r > 95, r == 50);
          step(r < 50 ? "R5" : "R6");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule